// File: doc/BRIEF.md
# ADC Conversion Start Trigger Selector

This block decides when an ADC front end begins a conversion. It watches a vector of 32 event lines and takes one of them, picked by a 5-bit select code, as the hardware start source. It looks for a chosen transition on that line: rising or falling, set by a polarity input. The resulting pulse is ORed with a software trigger, which comes from a register write strobe qualified by its data bit. The combined pulse leaves the block as a registered start strobe toward the converter, one clock wide.

Four select codes (7, 8, 9 and 10) carry no hardware event. With one of them selected, only software writes can start a conversion. Code 31 is meant for the converter's own completion interrupt, so one conversion can start the next. The start output is registered, so that feedback path has no combinational loop. Changing the select or the polarity reloads the edge detector without firing, so reconfiguration never produces a phantom start. The start strobe is only produced while the converter interface mode is "enabled". The event lines are taken as synchronous to `clk`.

Top module: `trig_sel_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `start_o` is 0.
- R2: With `fall_i` = 0, a 0-to-1 change on `evt_i[src_sel_i]` between two consecutive cycles raises `start_o` in the cycle after the 1 is seen, for exactly one cycle.
- R3: With `fall_i` = 1, a 1-to-0 change on the selected line raises `start_o` for one cycle in the same way, and a 0-to-1 change produces no start.
- R4: For any code outside 7..10, select code k makes line `evt_i[k]` the hardware source, and changes on every other line have no effect on `start_o`.
- R5: Select codes 7, 8, 9 and 10 never produce a hardware start, whatever `evt_i` does.
- R6: Code 31 selects `evt_i[31]`, the converter-interrupt feedback line, and behaves like any other source.
- R7: A cycle with `sw_wr_i` = 1 and `sw_bit_i` = 1 gives a one-cycle `start_o` pulse in the next cycle. A write with `sw_bit_i` = 0 gives none.
- R8: A software trigger and a hardware edge in the same cycle give one start cycle, not two.
- R9: In a cycle where `src_sel_i` or `fall_i` differs from its value in the previous cycle, no hardware start is produced, even if the newly selected level looks like an edge.
- R10: `if_mode_i` encodes 2'b00 off, 2'b01 enabled, 2'b11 flush, and 2'b10 is treated as off. `start_o` rises only after a cycle with mode 2'b01. An edge seen while not enabled is dropped, not held for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Candidate hardware event lines, synchronous to clk |
| src_sel_i | input | 5 | Hardware start source select code |
| fall_i | input | 1 | Edge polarity: 0 rising, 1 falling |
| sw_wr_i | input | 1 | Software trigger register write strobe |
| sw_bit_i | input | 1 | Data bit 0 of the software trigger write |
| if_mode_i | input | 2 | Converter interface mode (off, enabled, flush) |
| start_o | output | 1 | One-cycle conversion start strobe |

## Verification
Errors in the previous-level register or the configuration snapshot show up as a missing or extra `start_o` pulse. That pulse appears exactly one cycle after the input change that should or should not cause it. A stale snapshot after a select or polarity change shows as a phantom start in the very next cycle. A bad source decode shows up on the first edge of the affected line, which is why every source code is swept. A held-over edge shows up as a start on re-enable, with no new transition to cause it.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned N_EVT = 32;
  localparam int unsigned SEL_W = $clog2(N_EVT);

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_ON    = 2'b01,
    MODE_RSVD  = 2'b10,
    MODE_FLUSH = 2'b11
  } if_mode_e;

  // Select codes that carry no hardware event (7, 8, 9, 10)
  localparam logic [N_EVT-1:0] NOEV_MASK = 32'h0000_0780;
endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
  parameter int unsigned         NUM   = 32,
  parameter int unsigned         SW    = $clog2(NUM),
  parameter logic [NUM-1:0]      DEAD  = '0
) (
  input  logic [NUM-1:0] evt_i,
  input  logic [SW-1:0]  sel_i,
  output logic           lvl_o,
  output logic           live_o
);
  logic [NUM-1:0] gated;

  // Lines whose code means "no event" are tied low before selection
  for (genvar g = 0; g < NUM; g++) begin : g_gate
    if (DEAD[g]) begin : g_dead
      assign gated[g] = 1'b0;
    end else begin : g_live
      assign gated[g] = evt_i[g];
    end
  end

  assign lvl_o  = gated[sel_i];
  assign live_o = ~DEAD[sel_i];
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
  parameter int unsigned SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl_i,
  input  logic          live_i,
  input  logic [SW-1:0] sel_i,
  input  logic          fall_i,
  output logic          hit_o
);
  localparam int unsigned CFG_W = SW + 1;

  logic [CFG_W-1:0] cfg_q;
  logic             prev_q;
  logic             primed_q;
  logic             norm;
  logic             cfg_chg;

  // Fold polarity into the level so only 0->1 has to be found
  assign norm    = lvl_i ^ fall_i;
  assign cfg_chg = {sel_i, fall_i} != cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      prev_q   <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      cfg_q    <= {sel_i, fall_i};
      prev_q   <= norm;   // also reloads on reconfiguration
      primed_q <= 1'b1;
    end
  end

  assign hit_o = primed_q & ~cfg_chg & live_i & ~prev_q & norm;
endmodule

// File: rtl/trig_sel_top.sv
module trig_sel_top
  import trig_pkg::*;
#(
  parameter int unsigned NUM = N_EVT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM-1:0]         evt_i,
  input  logic [$clog2(NUM)-1:0] src_sel_i,
  input  logic                   fall_i,
  input  logic                   sw_wr_i,
  input  logic                   sw_bit_i,
  input  logic [1:0]             if_mode_i,
  output logic                   start_o
);
  localparam int unsigned SW = $clog2(NUM);

  logic lvl, live, hw_hit, sw_hit, en, start_q;

  trig_src_mux #(.NUM(NUM), .SW(SW), .DEAD(NOEV_MASK[NUM-1:0])) u_mux (
    .evt_i  (evt_i),
    .sel_i  (src_sel_i),
    .lvl_o  (lvl),
    .live_o (live)
  );

  trig_edge_det #(.SW(SW)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl),
    .live_i (live),
    .sel_i  (src_sel_i),
    .fall_i (fall_i),
    .hit_o  (hw_hit)
  );

  assign sw_hit = sw_wr_i & sw_bit_i;
  assign en     = (if_mode_i == MODE_ON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= en & (hw_hit | sw_hit);
  end

  assign start_o = start_q;
endmodule

// File: rtl/trig_sel_chk.sv
module trig_sel_chk
  import trig_pkg::*;
#(
  parameter int unsigned NUM = N_EVT
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM-1:0]         evt_i,
  input logic [$clog2(NUM)-1:0] src_sel_i,
  input logic                   fall_i,
  input logic                   sw_wr_i,
  input logic                   sw_bit_i,
  input logic [1:0]             if_mode_i,
  input logic                   start_o
);
  logic up_q;
  logic sel_lvl;
  logic sw_go;
  logic dead_sel;

  assign sel_lvl  = evt_i[src_sel_i];
  assign sw_go    = sw_wr_i & sw_bit_i;
  assign dead_sel = NOEV_MASK[src_sel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  // R10
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (if_mode_i != MODE_ON) |=> !start_o);

  // R7
  sw_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_go && if_mode_i == MODE_ON) |=> start_o);

  // R5
  dead_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dead_sel && !sw_go) |=> !start_o);

  // R9
  reconfig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && !sw_go && (!$stable(src_sel_i) || !$stable(fall_i))) |=> !start_o);

  // R2
  rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && if_mode_i == MODE_ON && !dead_sel && !fall_i &&
     $stable(fall_i) && $stable(src_sel_i) && $rose(sel_lvl)) |=> start_o);

  // R3
  fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && if_mode_i == MODE_ON && !dead_sel && fall_i &&
     $stable(fall_i) && $stable(src_sel_i) && $fell(sel_lvl)) |=> start_o);
endmodule

bind trig_sel_top trig_sel_chk #(.NUM(NUM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_i     (evt_i),
  .src_sel_i (src_sel_i),
  .fall_i    (fall_i),
  .sw_wr_i   (sw_wr_i),
  .sw_bit_i  (sw_bit_i),
  .if_mode_i (if_mode_i),
  .start_o   (start_o)
);

// File: tb/tb_trig_sel_top.sv
`timescale 1ns/1ps
module tb_trig_sel_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_i = '0;
  logic [4:0]  src_sel_i = '0;
  logic        fall_i = 1'b0;
  logic        sw_wr_i = 1'b0;
  logic        sw_bit_i = 1'b0;
  logic [1:0]  if_mode_i = 2'b01;
  logic        start_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  trig_sel_top dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .src_sel_i(src_sel_i),
    .fall_i(fall_i), .sw_wr_i(sw_wr_i), .sw_bit_i(sw_bit_i),
    .if_mode_i(if_mode_i), .start_o(start_o)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: start_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, queue the expected start for the next edge
  task automatic drive(input logic [31:0] e, input logic [4:0] s, input logic f,
                       input logic w, input logic b, input logic [1:0] m,
                       input bit exp, input string tag);
    @(negedge clk);
    evt_i = e; src_sel_i = s; fall_i = f; sw_wr_i = w; sw_bit_i = b; if_mode_i = m;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare right after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(start_o, exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: start_o=%0b expected run to finish", start_o);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    evt_i = 32'hFFFF_FFFF; src_sel_i = 5'd3;
    check(start_o, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R1 first cycle after reset, lines already high
    drive(32'hFFFF_FFFF, 5'd3, 0, 0, 0, 2'b01, 0, "R1 first cycle");
    drive(32'h0, 5'd3, 0, 0, 0, 2'b01, 0, "R2 settle low");
    drive(32'h8, 5'd3, 0, 0, 0, 2'b01, 1, "R2 rise fires");
    drive(32'h8, 5'd3, 0, 0, 0, 2'b01, 0, "R2 single cycle");
    drive(32'h0, 5'd3, 0, 0, 0, 2'b01, 0, "R3 fall ignored on rise pol");
    drive(32'h0, 5'd3, 1, 0, 0, 2'b01, 0, "R9 pol change");
    drive(32'h8, 5'd3, 1, 0, 0, 2'b01, 0, "R3 rise ignored on fall pol");
    drive(32'h0, 5'd3, 1, 0, 0, 2'b01, 1, "R3 fall fires");
    drive(32'h0, 5'd3, 1, 0, 0, 2'b01, 0, "R3 single cycle");
    // R9: select switch onto a high line
    drive(32'h20, 5'd3, 0, 0, 0, 2'b01, 0, "R9 pol back");
    drive(32'h20, 5'd3, 0, 0, 0, 2'b01, 0, "R9 steady");
    drive(32'h20, 5'd5, 0, 0, 0, 2'b01, 0, "R9 sel switch no phantom");
    drive(32'h20, 5'd5, 0, 0, 0, 2'b01, 0, "R9 after switch");
    drive(32'h20, 5'd5, 1, 0, 0, 2'b01, 0, "R9 pol to fall");
    drive(32'h20, 5'd5, 0, 0, 0, 2'b01, 0, "R9 pol flip no phantom");
    // R5 dead codes
    for (int c = 7; c <= 10; c++) begin
      drive(32'h0, 5'(c), 0, 0, 0, 2'b01, 0, "R5 select dead");
      drive(32'h0, 5'(c), 0, 0, 0, 2'b01, 0, "R5 low");
      drive(32'hFFFF_FFFF, 5'(c), 0, 0, 0, 2'b01, 0, "R5 rise ignored");
      drive(32'h0, 5'(c), 0, 1, 1, 2'b01, 1, "R5 sw still works");
    end
    // R4 sweep, R6 at code 31
    for (int s = 0; s < 32; s++) begin
      if (s >= 7 && s <= 10) continue;
      drive(32'h0, 5'(s), 0, 0, 0, 2'b01, 0, "R4 select");
      drive(~(32'h1 << s), 5'(s), 0, 0, 0, 2'b01, 0, "R4 other lines ignored");
      drive(32'h1 << s, 5'(s), 0, 0, 0, 2'b01, 1, (s == 31) ? "R6 feedback line" : "R4 own line");
      drive(32'h0, 5'(s), 0, 0, 0, 2'b01, 0, "R4 drop");
    end
    // R7 software trigger
    drive(32'h0, 5'd9, 0, 1, 1, 2'b01, 1, "R7 sw write one");
    drive(32'h0, 5'd9, 0, 0, 0, 2'b01, 0, "R7 single pulse");
    drive(32'h0, 5'd9, 0, 1, 0, 2'b01, 0, "R7 sw write zero");
    drive(32'h0, 5'd9, 0, 0, 1, 2'b01, 0, "R7 data without strobe");
    // R8 coincident
    drive(32'h0, 5'd2, 0, 0, 0, 2'b01, 0, "R8 setup");
    drive(32'h0, 5'd2, 0, 0, 0, 2'b01, 0, "R8 settle");
    drive(32'h4, 5'd2, 0, 1, 1, 2'b01, 1, "R8 hw and sw together");
    drive(32'h4, 5'd2, 0, 0, 0, 2'b01, 0, "R8 one cycle only");
    // R10 modes
    drive(32'h0, 5'd2, 0, 0, 0, 2'b00, 0, "R10 off low");
    drive(32'h4, 5'd2, 0, 0, 0, 2'b00, 0, "R10 edge while off");
    drive(32'h4, 5'd2, 0, 0, 0, 2'b01, 0, "R10 edge not held");
    drive(32'h4, 5'd2, 0, 1, 1, 2'b11, 0, "R10 flush blocks sw");
    drive(32'h4, 5'd2, 0, 1, 1, 2'b10, 0, "R10 code 2 blocks sw");
    drive(32'h0, 5'd2, 0, 0, 0, 2'b01, 0, "R10 low again");
    drive(32'h4, 5'd2, 0, 0, 0, 2'b01, 1, "R10 enabled edge");
    drive(32'h0, 5'd2, 0, 0, 0, 2'b01, 0, "R10 idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule